// File: doc/BRIEF.md
# Saturating PHY Error Event Counters

This block keeps two 8-bit event counters that sit in the management register space of an Ethernet PHY. One counter tallies false-carrier events, each signalled by a one-cycle strobe. The other tallies receive errors. A receive error is a carrier event that holds at least one invalid data symbol while a valid carrier is present. It is counted at most once per carrier event, and it is not counted at all if a collision is seen during that event.

Both counters stop at their all-ones value instead of wrapping. A read clears them, and a write loads them. Each counter is presented as a 16-bit register whose upper byte is always zero. The block takes a carrier-valid level, a collision level, a per-symbol invalid strobe and a false-carrier strobe from the receive datapath. A management agent reaches the counters through a plain port made of an address, write data and separate read and write strobes.

Top module: `phy_err_counters`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x0000.
- R2: Bits 15:8 of both read-data outputs are always zero, and write data in bits 15:8 has no effect.
- R3: Each counter stops at 0xFF. An increment at 0xFF leaves it at 0xFF.
- R4: A write strobe loads wdata[7:0] into the counter at the write address (0 = false-carrier, 1 = receive-error) on the next edge. Other addresses and the other counter are left unchanged.
- R5: A read strobe clears the addressed counter (address 0 = false-carrier, 1 = receive-error) on the next edge. A read-clear wins over an increment or a write to the same counter in the same cycle.
- R6: Each cycle in which the false-carrier strobe is high adds one to the false-carrier counter.
- R7: The receive-error counter adds one on the first invalid-symbol strobe seen while carrier is high. Further invalid symbols in the same carrier event, and invalid symbols while carrier is low, add nothing.
- R8: A collision seen at any point in a carrier event, up to and including the cycle of the invalid symbol, blocks the receive-error count for the rest of that event. The next carrier event counts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_i | input | 1 | Valid carrier present (level) |
| collision_i | input | 1 | Collision present (level) |
| sym_invalid_i | input | 1 | Invalid data symbol seen this cycle (strobe) |
| false_carrier_i | input | 1 | False-carrier event (strobe) |
| addr_i | input | 2 | Register address: 0 false-carrier, 1 receive-error |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; clears the addressed counter |
| fc_rdata_o | output | 16 | False-carrier register value |
| rx_rdata_o | output | 16 | Receive-error register value |

## Verification
The bench targets the corners where a counter would drift:
- **Repeated invalid symbols in one carrier.** A design without the per-event flag counts two or more.
- **Collisions.** A collision that comes before the invalid symbol, and one in the same cycle as it, must both block the count. A design that checks only the current cycle lets the late symbol through.
- **Saturation.** Stepping each counter past 0xFF must leave it at 0xFF. A wrapping counter shows 0x00.
- **Same-cycle collisions of strobes.** A read-clear is paired with an increment, and separately with a write. A design that gives the increment or the write priority leaves a nonzero value.
- **Upper byte and unused address.** The bench writes data with the upper byte set and writes to an address with no register. Any leak shows up in bits 15:8 or in a changed counter.

// File: rtl/phy_errcnt_pkg.sv
// Package: shared sizing and counter indices for the PHY error counters.
// Assumes counter index equals its register address.
package phy_errcnt_pkg;
    localparam int CNT_W   = 8;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int NUM_CNT = 2;

    typedef enum logic [ADDR_W-1:0] {
        IDX_FALSE_CARRIER = 2'd0,
        IDX_RX_ERROR      = 2'd1
    } cnt_idx_e;
endpackage

// File: rtl/sat_counter.sv
// Module: sat_counter
// Saturating event counter with a synchronous clear and a parallel load.
// Priority: clear, then load, then increment. Holds at all ones.
// Assumes one increment per cycle at most.
module sat_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

    logic [WIDTH-1:0] count_q;

    // Update the count by priority: reset, clear, load, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                         count_q <= '0;
        else if (clr_i)                     count_q <= '0;
        else if (load_i)                    count_q <= load_val_i;
        else if (inc_i && count_q != MAX_VAL) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == MAX_VAL && !clr_i && !load_i) |=> count_q == MAX_VAL); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_q == '0); // R5
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> count_q == $past(load_val_i)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i && !load_i) |=> $stable(count_q)); // R6
endmodule

// File: rtl/rxerr_qualifier.sv
// Module: rxerr_qualifier
// Turns per-symbol invalid strobes into at most one count pulse per
// carrier event. A collision anywhere in the event suppresses the pulse.
// Assumes the carrier level marks event boundaries.
module rxerr_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_i,
    input  logic collision_i,
    input  logic sym_invalid_i,
    output logic count_o
);
    logic counted_q;
    logic coll_seen_q;
    logic pulse;

    // Decide whether this cycle's invalid symbol is the one to count.
    always_comb begin
        pulse = carrier_i && sym_invalid_i && !counted_q
                && !coll_seen_q && !collision_i;
    end

    // Track the per-event counted and collision flags; both drop with carrier.
    always_ff @(posedge clk) begin
        if (!rst_n || !carrier_i) begin
            counted_q   <= 1'b0;
            coll_seen_q <= 1'b0;
        end else begin
            if (pulse)       counted_q   <= 1'b1;
            if (collision_i) coll_seen_q <= 1'b1;
        end
    end

    assign count_o = pulse;

    AST_ONCE_PER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o && carrier_i) |=> !count_o); // R7
    AST_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_i |-> !count_o); // R7
    AST_COLL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_i && collision_i) |=> (carrier_i -> !count_o)); // R8
endmodule

// File: rtl/phy_err_counters.sv
// Module: phy_err_counters (top)
// Two saturating, clear-on-read error counters behind a simple register
// port. Counter i sits at address i and occupies bits 7:0 of its register.
// Assumes the read data is captured in the cycle the read strobe is high.
module phy_err_counters
    import phy_errcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_i,
    input  logic              collision_i,
    input  logic              sym_invalid_i,
    input  logic              false_carrier_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [REG_W-1:0]  fc_rdata_o,
    output logic [REG_W-1:0]  rx_rdata_o
);
    localparam int PAD_W = REG_W - CNT_W;

    logic [NUM_CNT-1:0] inc;
    logic [CNT_W-1:0]   count [NUM_CNT];
    logic               rx_pulse;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[REG_W-1:CNT_W];

    rxerr_qualifier u_rxq (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier_i    (carrier_i),
        .collision_i  (collision_i),
        .sym_invalid_i(sym_invalid_i),
        .count_o      (rx_pulse)
    );

    // Route each event source to its counter index.
    always_comb begin
        inc                    = '0;
        inc[IDX_FALSE_CARRIER] = false_carrier_i;
        inc[IDX_RX_ERROR]      = rx_pulse;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic hit;
        assign hit = (addr_i == ADDR_W'(g));
        sat_counter #(.WIDTH(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc[g]),
            .clr_i     (rd_i && hit),
            .load_i    (wr_i && hit),
            .load_val_i(wdata_i[CNT_W-1:0]),
            .count_o   (count[g])
        );
    end

    assign fc_rdata_o = {{PAD_W{1'b0}}, count[IDX_FALSE_CARRIER]};
    assign rx_rdata_o = {{PAD_W{1'b0}}, count[IDX_RX_ERROR]};

    AST_FC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (false_carrier_i && !wr_i && !rd_i && fc_rdata_o[CNT_W-1:0] != {CNT_W{1'b1}})
        |=> fc_rdata_o == $past(fc_rdata_o) + 1'b1); // R6
    AST_OTHER_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= ADDR_W'(NUM_CNT) && !false_carrier_i && !sym_invalid_i)
        |=> $stable(fc_rdata_o) && $stable(rx_rdata_o)); // R4
endmodule

// File: tb/tb_phy_err_counters.sv
// Bench: a vector table walked by one loop, then directed reset and corner tests.
module tb_phy_err_counters;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        carrier, collision, sym_inv, fcs;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic        wr, rd;
    logic [15:0] fc_rdata, rx_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    phy_err_counters dut (
        .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .collision_i(collision),
        .sym_invalid_i(sym_inv), .false_carrier_i(fcs), .addr_i(addr),
        .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
        .fc_rdata_o(fc_rdata), .rx_rdata_o(rx_rdata)
    );

    // Vector: car col sym fcs wr rd addr[2] wdata[16] exp_fc[8] exp_rx[8] = 40 bits
    localparam int NV = 25;
    localparam logic [39:0] VEC [NV] = '{
        {6'b000000, 2'd0, 16'h0000, 8'h00, 8'h00}, // R1 idle
        {6'b000100, 2'd0, 16'h0000, 8'h01, 8'h00}, // R6
        {6'b000100, 2'd0, 16'h0000, 8'h02, 8'h00}, // R6
        {6'b100000, 2'd0, 16'h0000, 8'h02, 8'h00}, // R7 carrier only
        {6'b101000, 2'd0, 16'h0000, 8'h02, 8'h01}, // R7 first symbol
        {6'b101000, 2'd0, 16'h0000, 8'h02, 8'h01}, // R7 once per event
        {6'b000000, 2'd0, 16'h0000, 8'h02, 8'h01},
        {6'b001000, 2'd0, 16'h0000, 8'h02, 8'h01}, // R7 no carrier
        {6'b110000, 2'd0, 16'h0000, 8'h02, 8'h01}, // R8 collision first
        {6'b101000, 2'd0, 16'h0000, 8'h02, 8'h01}, // R8 blocked later
        {6'b000000, 2'd0, 16'h0000, 8'h02, 8'h01},
        {6'b101000, 2'd0, 16'h0000, 8'h02, 8'h02}, // R8 next event counts
        {6'b000001, 2'd1, 16'h0000, 8'h02, 8'h00}, // R5 read clears rx
        {6'b000101, 2'd0, 16'h0000, 8'h00, 8'h00}, // R5 clear beats inc
        {6'b000010, 2'd0, 16'hABFE, 8'hFE, 8'h00}, // R4 R2 load low byte
        {6'b000100, 2'd0, 16'h0000, 8'hFF, 8'h00}, // R6
        {6'b000100, 2'd0, 16'h0000, 8'hFF, 8'h00}, // R3 fc saturates
        {6'b000010, 2'd1, 16'h12FF, 8'hFF, 8'hFF}, // R4 load rx
        {6'b101000, 2'd0, 16'h0000, 8'hFF, 8'hFF}, // R3 rx saturates
        {6'b000000, 2'd0, 16'h0000, 8'hFF, 8'hFF},
        {6'b000010, 2'd2, 16'h0055, 8'hFF, 8'hFF}, // R4 unused address
        {6'b000001, 2'd1, 16'h0000, 8'hFF, 8'h00}, // R5
        {6'b111000, 2'd0, 16'h0000, 8'hFF, 8'h00}, // R8 same-cycle collision
        {6'b000000, 2'd0, 16'h0000, 8'hFF, 8'h00},
        {6'b000011, 2'd0, 16'h0011, 8'h00, 8'h00}  // R5 clear beats write
    };

    task automatic idle_inputs();
        carrier = 0; collision = 0; sym_inv = 0; fcs = 0;
        addr = 0; wdata = 0; wr = 0; rd = 0;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 fc reset", fc_rdata, 16'h0000);
        check("R1 rx reset", rx_rdata, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            {carrier, collision, sym_inv, fcs, wr, rd} = VEC[i][39:34];
            addr  = VEC[i][33:32];
            wdata = VEC[i][31:16];
            @(negedge clk);
            check($sformatf("R2-R8 vec%0d fc", i), fc_rdata, {8'h00, VEC[i][15:8]});
            check($sformatf("R2-R8 vec%0d rx", i), rx_rdata, {8'h00, VEC[i][7:0]});
            check("R2 upper byte", {fc_rdata[15:8], rx_rdata[15:8]}, 16'h0000);
        end

        // Directed: reset mid-run clears both counters (R1)
        idle_inputs();
        fcs = 1; @(negedge clk);
        addr = 1; wr = 1; fcs = 0; wdata = 16'h0033; @(negedge clk);
        idle_inputs();
        check("R6 pre-reset fc", fc_rdata, 16'h0001);
        check("R4 pre-reset rx", rx_rdata, 16'h0033);
        rst_n = 0; @(negedge clk); rst_n = 1;
        check("R1 fc after reset", fc_rdata, 16'h0000);
        check("R1 rx after reset", rx_rdata, 16'h0000);

        // Directed: read of rx in the cycle its symbol would count (R5)
        carrier = 1; sym_inv = 1; rd = 1; addr = 1; @(negedge clk);
        rd = 0; @(negedge clk);
        check("R5 clear beats rx inc", rx_rdata, 16'h0000);
        carrier = 0; sym_inv = 0; @(negedge clk);
        check("R7 flag kept after clear", rx_rdata, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule